// File: doc/BRIEF.md
# Self-Seeding Parallel PRBS Frame Checker

This block receives wide frames of pseudo-random data, one frame per enable strobe, and decides for each frame whether it continues the sequence started by the previous one. The sequence follows the recurrence s[n] = s[n-23] XOR s[n-18], which is the x^23 + x^18 + 1 polynomial. The checker has no seed input. It takes the newest 23 bits of each received frame as the state of the sequence, unrolls the recurrence across the full frame width in one step, and uses the result as the prediction for the next frame.

A mismatch raises an error flag. The flag holds its value until the next frame has been judged. A lock flag with hysteresis sits on top of the per-frame verdicts. It rises after a run of consecutive good frames and falls after a run of consecutive bad frames, and the two run lengths are set separately. The frame width defaults to 234 bits: a 230-bit payload plus two 2-bit side fields. In typical use the strobe is high for one clock cycle in eight.

Top module: `prbs_lock_checker`

## Requirements
- R1: While `rst` is high and on the first clock edge after it, `err_o` and `lock_o` are 0 and `expect_o` is all zeros.
- R2: Frame bit 0 carries the oldest sequence bit and bit FRAME_W-1 the newest. At the edge that samples a frame with `en_i` high, `expect_o` takes the prediction for that frame. The prediction is built from bits FRAME_W-23 to FRAME_W-1 of the frame sampled at the previous strobe, extended with s[n] = s[n-23] ^ s[n-18].
- R3: No verdict is made for the first frame after reset. `err_o` stays 0 and no run counting takes place until the second frame has been sampled.
- R4: A verdict is made on the clock edge that follows a strobe edge. It sets `err_o` to 1 if the sampled frame differs from `expect_o`, or to 0 if it matches. `err_o` holds that value until the next verdict.
- R5: A frame that is corrupted only in bits below FRAME_W-23 is flagged on its own. The frame after it is judged good.
- R6: A frame that is corrupted in its top 23 bits is flagged, and so is the frame after it. The frame after those two is judged good.
- R7: While unlocked, `lock_o` rises on the verdict that completes GOOD_RUN+2 consecutive good frames, and not before.
- R8: While unlocked, a bad verdict restarts the good-frame run from zero.
- R9: While locked, `lock_o` falls on the verdict that completes BAD_RUN+2 consecutive bad frames. A good verdict restarts the bad-frame run from zero.
- R10: While `en_i` is low, changes on `frame_i` have no effect. `expect_o`, `err_o` and `lock_o` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Frame strobe; the frame is sampled while high |
| frame_i | input | FRAME_W | Received frame, bit 0 oldest |
| expect_o | output | FRAME_W | Predicted frame for the last sampled frame |
| err_o | output | 1 | Verdict of the last judged frame, 1 = mismatch |
| lock_o | output | 1 | Hysteresis lock flag |

## Verification
A corrupted predictor state shows up on `expect_o` right after the next strobe edge, and on `err_o` one clock later. A tail fault persists for exactly two frames, so a wrong choice of tail bits or a wrong tap shows up as an error on every frame. A run counter that is off by one shows up only at the boundary frame: `lock_o` rises or falls one frame early or one frame late. The bench therefore samples the lock flag on both sides of each threshold.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  typedef enum logic [1:0] {
    PRIME_EMPTY = 2'd0,
    PRIME_ONE   = 2'd1,
    PRIME_FULL  = 2'd2
  } prime_e;

  function automatic int unsigned run_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/prbs_frame_predictor.sv
module prbs_frame_predictor #(
  parameter int unsigned FRAME_W  = 234,
  parameter int unsigned POLY_DEG = 23,
  parameter int unsigned POLY_TAP = 18
) (
  input  logic [POLY_DEG-1:0] tail_i,
  output logic [FRAME_W-1:0]  next_o
);
  localparam int unsigned EXT_W  = POLY_DEG + FRAME_W;
  localparam int unsigned NEAR_D = POLY_DEG - POLY_TAP;

  logic [EXT_W-1:0] ext;

  assign ext[POLY_DEG-1:0] = tail_i;

  for (genvar j = 0; j < FRAME_W; j++) begin : g_unroll
    assign ext[POLY_DEG+j] = ext[j] ^ ext[j+NEAR_D];
  end

  assign next_o = ext[EXT_W-1:POLY_DEG];

endmodule

// File: rtl/prbs_lock_hyst.sv
module prbs_lock_hyst #(
  parameter int unsigned LOCK_N   = 17,
  parameter int unsigned UNLOCK_N = 22
) (
  input  logic clk,
  input  logic rst,
  input  logic verdict_v,
  input  logic verdict_bad,
  output logic err_o,
  output logic lock_o
);
  import prbs_chk_pkg::*;

  localparam int unsigned GW = run_width(LOCK_N);
  localparam int unsigned BW = run_width(UNLOCK_N);
  localparam logic [GW-1:0] GOOD_LAST = GW'(LOCK_N - 1);
  localparam logic [BW-1:0] BAD_LAST  = BW'(UNLOCK_N - 1);

  logic [GW-1:0] good_run;
  logic [BW-1:0] bad_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      good_run <= '0;
      bad_run  <= '0;
      err_o    <= 1'b0;
      lock_o   <= 1'b0;
    end else if (verdict_v) begin
      err_o <= verdict_bad;
      if (!lock_o) begin
        bad_run <= '0;
        if (verdict_bad) begin
          good_run <= '0;
        end else if (good_run == GOOD_LAST) begin
          good_run <= '0;
          lock_o   <= 1'b1;
        end else begin
          good_run <= good_run + 1'b1;
        end
      end else begin
        good_run <= '0;
        if (!verdict_bad) begin
          bad_run <= '0;
        end else if (bad_run == BAD_LAST) begin
          bad_run <= '0;
          lock_o  <= 1'b0;
        end else begin
          bad_run <= bad_run + 1'b1;
        end
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!lock_o && !err_o));

  p_hold_no_verdict_r4: assert property (@(posedge clk) disable iff (rst)
    !verdict_v |=> ($stable(err_o) && $stable(lock_o)));

  p_lock_rise_good_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_o) |-> $past(verdict_v && !verdict_bad));

  p_lock_fall_bad_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(lock_o) |-> $past(verdict_v && verdict_bad));

  p_good_run_bound_r8: assert property (@(posedge clk) disable iff (rst)
    (good_run <= GOOD_LAST) && (bad_run <= BAD_LAST));

endmodule

// File: rtl/prbs_lock_checker.sv
module prbs_lock_checker #(
  parameter int unsigned FRAME_W  = 234,
  parameter int unsigned POLY_DEG = 23,
  parameter int unsigned POLY_TAP = 18,
  parameter int unsigned GOOD_RUN = 15,
  parameter int unsigned BAD_RUN  = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [FRAME_W-1:0] expect_o,
  output logic               err_o,
  output logic               lock_o
);
  import prbs_chk_pkg::*;

  localparam int unsigned TAIL_LO  = FRAME_W - POLY_DEG;
  localparam int unsigned LOCK_N   = GOOD_RUN + 2;
  localparam int unsigned UNLOCK_N = BAD_RUN + 2;

  logic [FRAME_W-1:0] data_q;
  logic [FRAME_W-1:0] pred_q;
  logic [FRAME_W-1:0] pred_next;
  logic               en_d;
  prime_e             prime_q;
  logic               verdict_v;
  logic               verdict_bad;

  prbs_frame_predictor #(
    .FRAME_W (FRAME_W),
    .POLY_DEG(POLY_DEG),
    .POLY_TAP(POLY_TAP)
  ) u_pred (
    .tail_i(data_q[FRAME_W-1:TAIL_LO]),
    .next_o(pred_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      pred_q  <= '0;
      en_d    <= 1'b0;
      prime_q <= PRIME_EMPTY;
    end else begin
      en_d <= en_i;
      if (en_i) begin
        data_q <= frame_i;
        pred_q <= pred_next;
        case (prime_q)
          PRIME_EMPTY: prime_q <= PRIME_ONE;
          default:     prime_q <= PRIME_FULL;
        endcase
      end
    end
  end

  assign verdict_v   = en_d && (prime_q == PRIME_FULL);
  assign verdict_bad = (data_q != pred_q);
  assign expect_o    = pred_q;

  prbs_lock_hyst #(
    .LOCK_N  (LOCK_N),
    .UNLOCK_N(UNLOCK_N)
  ) u_hyst (
    .clk        (clk),
    .rst        (rst),
    .verdict_v  (verdict_v),
    .verdict_bad(verdict_bad),
    .err_o      (err_o),
    .lock_o     (lock_o)
  );

  p_expect_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(expect_o));

  p_no_early_err_r3: assert property (@(posedge clk) disable iff (rst)
    (prime_q != PRIME_FULL) |=> !err_o);

endmodule

// File: tb/prbs_lock_checker_bench.sv
module prbs_lock_checker_bench;
  localparam int W       = 234;
  localparam int LOCKN   = 17;
  localparam int UNLOCKN = 22;

  logic         clk = 1'b0;
  logic         rst;
  logic         en;
  logic [W-1:0] frame;
  logic [W-1:0] expect_w;
  logic         err_w;
  logic         lock_w;

  int n_tests = 0;
  int n_fail  = 0;
  logic [22:0]  sr;
  logic [W-1:0] clean;
  logic [W-1:0] got_exp;
  logic         got_err;
  logic         got_lock;
  bit           idle_ok;

  always #10 clk = ~clk;

  prbs_lock_checker u_prbs_lock_checker (
    .clk(clk), .rst(rst), .en_i(en), .frame_i(frame),
    .expect_o(expect_w), .err_o(err_w), .lock_o(lock_w)
  );

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_clean();
    for (int i = 0; i < W; i++) begin
      logic b;
      b = sr[22] ^ sr[17];
      clean[i] = b;
      sr = {sr[21:0], b};
    end
  endtask

  task automatic send(input logic [W-1:0] f);
    @(negedge clk);
    en = 1'b1; frame = f;
    @(negedge clk);
    en = 1'b0; frame = ~f;
    got_exp = expect_w;
    @(negedge clk);
    got_err = err_w; got_lock = lock_w;
    idle_ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      frame = frame ^ {W{k[0]}};
      @(negedge clk);
      if (err_w !== got_err || lock_w !== got_lock || expect_w !== got_exp) idle_ok = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; en = 1'b0;
    repeat (3) @(negedge clk);
    check(err_w === 1'b0 && lock_w === 1'b0 && expect_w === '0, "R1 reset state",
          {err_w, lock_w}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(err_w === 1'b0 && lock_w === 1'b0, "R1 after release", {err_w, lock_w}, 0);
  endtask

  task automatic t_first_and_lock();
    sr = 23'h5A3C1F;
    next_clean();
    send(clean ^ {{(W-3){1'b0}}, 3'b101});
    check(got_err === 1'b0, "R3 first frame no verdict", got_err, 0);
    for (int k = 1; k <= LOCKN; k++) begin
      next_clean();
      send(clean);
      if (k == 1 || k == LOCKN) check(got_exp === clean, "R2 prediction", got_exp, clean);
      check(got_err === 1'b0, "R4 good frame err", got_err, 0);
      if (k == LOCKN - 1) check(got_lock === 1'b0, "R7 not locked early", got_lock, 0);
      if (k == LOCKN)     check(got_lock === 1'b1, "R7 locks at threshold", got_lock, 1);
    end
    check(idle_ok, "R10 idle stable", idle_ok, 1);
  endtask

  task automatic t_single_bits();
    next_clean();
    send(clean ^ {{(W-1){1'b0}}, 1'b1});
    check(got_err === 1'b1, "R4 low-bit corruption flagged", got_err, 1);
    check(idle_ok, "R10 err held with frame toggling", idle_ok, 1);
    next_clean(); send(clean);
    check(got_err === 1'b0, "R5 next frame good", got_err, 0);
    next_clean();
    send(clean ^ {1'b1, {(W-1){1'b0}}});
    check(got_err === 1'b1, "R6 tail corruption flagged", got_err, 1);
    next_clean(); send(clean);
    check(got_err === 1'b1, "R6 following frame flagged", got_err, 1);
    next_clean(); send(clean);
    check(got_err === 1'b0, "R6 recovers", got_err, 0);
    check(got_lock === 1'b1, "R9 short bad runs keep lock", got_lock, 1);
  endtask

  task automatic t_unlock();
    for (int k = 0; k < UNLOCKN - 1; k++) begin
      next_clean(); send(clean ^ {{(W-1){1'b0}}, 1'b1});
    end
    check(got_lock === 1'b1, "R9 locked before threshold", got_lock, 1);
    next_clean(); send(clean);
    check(got_lock === 1'b1 && got_err === 1'b0, "R9 good restarts bad run", got_lock, 1);
    for (int k = 1; k <= UNLOCKN; k++) begin
      next_clean(); send(clean ^ {{(W-1){1'b0}}, 1'b1});
      if (k == UNLOCKN - 1) check(got_lock === 1'b1, "R9 not unlocked early", got_lock, 1);
      if (k == UNLOCKN)     check(got_lock === 1'b0, "R9 unlocks at threshold", got_lock, 0);
    end
  endtask

  task automatic t_relock_restart();
    for (int k = 0; k < 10; k++) begin
      next_clean(); send(clean);
    end
    next_clean(); send(clean ^ {{(W-1){1'b0}}, 1'b1});
    check(got_err === 1'b1, "R8 bad frame while unlocked", got_err, 1);
    for (int k = 1; k <= LOCKN; k++) begin
      next_clean(); send(clean);
      if (k == LOCKN - 1) check(got_lock === 1'b0, "R8 run restarted", got_lock, 0);
      if (k == LOCKN)     check(got_lock === 1'b1, "R8 relock after full run", got_lock, 1);
    end
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; frame = '0;
    do_reset();
    t_first_and_lock();
    t_single_bits();
    t_unlock();
    t_relock_restart();
    do_reset();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule